// File: doc/BRIEF.md
# Open-Page DRAM Command Sequencer

This block schedules read traffic for one DRAM channel made of a single rank with eight banks. Read requests carrying a bank, a row, a column and a tag arrive over a valid/ready stream and wait in a four-entry queue. For every bank the block remembers whether a row is open and which one. It then drives one command per cycle (precharge, activate or column read) while it enforces fixed cycle timings. A request to the open row of its bank needs only a column read. A request to another row needs a precharge, an activate and then a column read. A request to a closed bank starts with the activate.

Back-pressure: `req_ready` is high while fewer than four requests are pending. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. A sender that sees `req_ready` low must hold its request stable until it is taken. The command bus and the read-data strobe have no back-pressure. Each column read produces a window of four cycles on `rd_valid`, which starts 13 cycles after the read. `rd_tag` carries the tag of the request during that window.

Top module: `rbs_sched`

## Requirements
- R1: After reset every bank is closed, and the first command for a request to a closed bank is an activate (`cmd_kind`=2), with no precharge before it.
- R2: A request whose bank holds a different open row is served by a precharge (`cmd_kind`=1), then 13 cycles later an activate, then 13 cycles later a column read (`cmd_kind`=3), all to that bank.
- R3: A request whose row is already open in its bank is served by one column read alone.
- R4: `rd_valid` goes high exactly 13 cycles after a column read appears on the bus and stays high for 4 consecutive cycles, with `rd_tag` equal to that request's tag.
- R5: Two column reads on the bus are at least 4 cycles apart, and are exactly 4 apart when both are otherwise ready.
- R6: A precharge to a bank is issued no sooner than 13 cycles after the last column read to that bank, and exactly then when it is otherwise ready.
- R7: At most one command is driven per cycle, and commands to different banks may go out in consecutive cycles.
- R8: Among the requests whose next command is legal, the oldest wins. Requests to the same bank are served in arrival order. A younger request may pass an older one that is waiting on another bank.
- R9: `req_ready` is high out of reset and low while four requests are pending, and no request is taken while it is low.
- R10: An isolated row miss gives its first data 39 cycles after its precharge, and an isolated row hit gives its first data 13 cycles after its column read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue can take a request |
| req_bank | input | 3 | Target bank |
| req_row | input | 14 | Target row |
| req_col | input | 10 | Target column |
| req_tag | input | 4 | Request identifier |
| cmd_valid | output | 1 | A command is on the bus this cycle |
| cmd_kind | output | 2 | 0 none, 1 precharge, 2 activate, 3 column read |
| cmd_bank | output | 3 | Bank of the command |
| cmd_row | output | 14 | Row of the request behind the command |
| cmd_col | output | 10 | Column of the request behind the command |
| rd_valid | output | 1 | Data beat on the channel |
| rd_tag | output | 4 | Tag of the burst in flight |

## Verification
The bench starts from a closed bank, so a design that precharged a bank that was never opened would put an extra command on the bus. It times a hit followed by a miss to the same bank: a design that let the precharge go before CL ran out after the read, or that waited longer, shows a different gap. Three closed banks are opened back to back to check that activates go out in consecutive cycles and that their reads are spaced by four cycles. A sequencer that serialised banks, or that let reads collide, breaks one of these gaps. Four misses to one bank fill the queue to check back-pressure and in-order service. A younger hit on an open bank must also pass an older request that is waiting on its own activate. A scheduler that kept strict order would deliver those two tags in the wrong order.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_PRE = 2'd1,
    CMD_ACT = 2'd2,
    CMD_RD  = 2'd3
  } cmd_e;
endpackage

// File: rtl/rbs_queue.sv
// Pending-request store: entries stay packed toward slot 0, slot 0 is oldest.
module rbs_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic [W-1:0]              push_data,
  input  logic                      pop,
  input  logic [IW-1:0]             pop_idx,
  output logic [DEPTH-1:0]          vld_o,
  output logic [DEPTH-1:0][W-1:0]   data_o,
  output logic                      full_o
);
  logic [DEPTH-1:0]        vld_q, shv, nv;
  logic [DEPTH-1:0][W-1:0] mem_q, shm, nm;

  // Close the gap left by a removed entry.
  for (genvar g = 0; g < DEPTH; g++) begin : g_sh
    logic take_next;
    assign take_next = pop && (IW'(g) >= pop_idx);
    if (g < DEPTH-1) begin : g_mid
      assign shv[g] = take_next ? vld_q[g+1] : vld_q[g];
      assign shm[g] = take_next ? mem_q[g+1] : mem_q[g];
    end else begin : g_last
      assign shv[g] = take_next ? 1'b0 : vld_q[g];
      assign shm[g] = mem_q[g];
    end
  end

  // Append the new request at the first free slot.
  always_comb begin
    logic found;
    nv    = shv;
    nm    = shm;
    found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (push && !found && !shv[i]) begin
        nv[i] = 1'b1;
        nm[i] = push_data;
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= nv;
  end

  always_ff @(posedge clk) mem_q <= nm;

  assign vld_o  = vld_q;
  assign data_o = mem_q;
  assign full_o = vld_q[DEPTH-1];

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !vld_q[DEPTH-1]);
  p_pop_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> vld_q[pop_idx]);
endmodule

// File: rtl/rbs_bank.sv
// One bank: open-row record plus two countdowns.
//   tw: cycles left before ACT (after PRE) or CAS (after ACT) is legal
//   tp: cycles left before PRE is legal after the last CAS
module rbs_bank
  import rbs_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int T_RP  = 13,
  parameter int T_RCD = 13,
  parameter int T_CL  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_en,
  input  cmd_e             cmd_kind,
  input  logic [ROW_W-1:0] cmd_row,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             wait_done_o,
  output logic             pre_ok_o
);
  localparam int TMAX = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int TWW  = $clog2(TMAX + 1);
  localparam int TPW  = $clog2(T_CL + 1);

  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic [TWW-1:0]   tw_q;
  logic [TPW-1:0]   tp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
      tw_q   <= '0;
      tp_q   <= '0;
    end else begin
      if (tw_q != '0) tw_q <= tw_q - 1'b1;
      if (tp_q != '0) tp_q <= tp_q - 1'b1;
      if (cmd_en) begin
        case (cmd_kind)
          CMD_PRE: begin open_q <= 1'b0; tw_q <= TWW'(T_RP - 1); end
          CMD_ACT: begin open_q <= 1'b1; row_q <= cmd_row; tw_q <= TWW'(T_RCD - 1); end
          CMD_RD:  tp_q <= TPW'(T_CL - 1);
          default: ;
        endcase
      end
    end
  end

  assign open_o      = open_q;
  assign row_o       = row_q;
  assign wait_done_o = (tw_q == '0);
  assign pre_ok_o    = (tw_q == '0) && (tp_q == '0);

  p_act_closed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && cmd_kind == CMD_ACT) |-> (!open_q && tw_q == '0));
  p_cas_open_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && cmd_kind == CMD_RD) |-> (open_q && row_q == cmd_row && tw_q == '0));
  p_pre_after_cl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && cmd_kind == CMD_PRE) |-> (open_q && tp_q == '0 && tw_q == '0));
endmodule

// File: rtl/rbs_beat.sv
// Delays each column read by CL and stretches it into a burst window.
module rbs_beat #(
  parameter int T_CL    = 13,
  parameter int T_BURST = 4,
  parameter int TAG_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cas_en,
  input  logic [TAG_W-1:0] cas_tag,
  output logic             dv_o,
  output logic [TAG_W-1:0] dv_tag_o
);
  localparam int BW = $clog2(T_BURST + 1);

  logic [T_CL-1:0]            pv_q;
  logic [T_CL-1:0][TAG_W-1:0] pt_q;
  logic [BW-1:0]              bc_q;
  logic [TAG_W-1:0]           tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv_q  <= '0;
      bc_q  <= '0;
      tag_q <= '0;
    end else begin
      pv_q <= {pv_q[T_CL-2:0], cas_en};
      if (pv_q[T_CL-1]) begin
        bc_q  <= BW'(T_BURST);
        tag_q <= pt_q[T_CL-1];
      end else if (bc_q != '0) begin
        bc_q <= bc_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) pt_q <= {pt_q[T_CL-2:0], cas_tag};

  assign dv_o     = (bc_q != '0);
  assign dv_tag_o = tag_q;

  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pv_q[T_CL-1] |-> (bc_q <= BW'(1)));
  p_burst_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bc_q <= BW'(T_BURST));
endmodule

// File: rtl/rbs_sched.sv
module rbs_sched
  import rbs_pkg::*;
#(
  parameter int NBANK   = 8,
  parameter int ROW_W   = 14,
  parameter int COL_W   = 10,
  parameter int TAG_W   = 4,
  parameter int QDEPTH  = 4,
  parameter int T_RP    = 13,
  parameter int T_RCD   = 13,
  parameter int T_CL    = 13,
  parameter int T_BURST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_bank,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [TAG_W-1:0] req_tag,
  output logic             cmd_valid,
  output logic [1:0]       cmd_kind,
  output logic [2:0]       cmd_bank,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag
);
  localparam int BK_W = $clog2(NBANK);
  localparam int EW   = BK_W + ROW_W + COL_W + TAG_W;
  localparam int QIW  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int GW   = $clog2(T_BURST + 1);

  // queue
  logic                         push, pop, q_full;
  logic [QDEPTH-1:0]            q_vld;
  logic [QDEPTH-1:0][EW-1:0]    q_data;
  logic [QIW-1:0]               pick_idx;
  logic                         pick;

  assign req_ready = !q_full;
  assign push      = req_valid && req_ready;

  rbs_queue #(.DEPTH(QDEPTH), .W(EW)) u_queue (
    .clk, .rst_n,
    .push, .push_data({req_bank[BK_W-1:0], req_row, req_col, req_tag}),
    .pop, .pop_idx(pick_idx),
    .vld_o(q_vld), .data_o(q_data), .full_o(q_full)
  );

  // bank state
  logic [NBANK-1:0]            b_open, b_wait, b_pre;
  logic [NBANK-1:0][ROW_W-1:0] b_row;
  logic [GW-1:0]               gap_q;

  // per-entry next command and legality
  logic [QDEPTH-1:0][BK_W-1:0]  e_bank;
  logic [QDEPTH-1:0][ROW_W-1:0] e_row;
  logic [QDEPTH-1:0][COL_W-1:0] e_col;
  logic [QDEPTH-1:0][TAG_W-1:0] e_tag;
  logic [QDEPTH-1:0][1:0]       e_kind;
  logic [QDEPTH-1:0]            e_ok;

  for (genvar g = 0; g < QDEPTH; g++) begin : g_ent
    logic hit;
    assign {e_bank[g], e_row[g], e_col[g], e_tag[g]} = q_data[g];
    assign hit = b_open[e_bank[g]] && (b_row[e_bank[g]] == e_row[g]);
    assign e_kind[g] = !b_open[e_bank[g]] ? CMD_ACT : (hit ? CMD_RD : CMD_PRE);
    assign e_ok[g] = q_vld[g] &&
                     (!b_open[e_bank[g]] ? b_wait[e_bank[g]] :
                      hit ? (b_wait[e_bank[g]] && gap_q == '0) : b_pre[e_bank[g]]);
  end

  // oldest legal entry wins; an entry is skipped when an older one targets its bank
  always_comb begin
    logic [NBANK-1:0] seen;
    seen     = '0;
    pick     = 1'b0;
    pick_idx = '0;
    for (int i = 0; i < QDEPTH; i++) begin
      if (q_vld[i]) begin
        if (!pick && !seen[e_bank[i]] && e_ok[i]) begin
          pick     = 1'b1;
          pick_idx = QIW'(i);
        end
        seen[e_bank[i]] = 1'b1;
      end
    end
  end

  cmd_e             sel_kind;
  logic [BK_W-1:0]  sel_bank;
  assign sel_kind = cmd_e'(e_kind[pick_idx]);
  assign sel_bank = e_bank[pick_idx];
  assign pop      = pick && (sel_kind == CMD_RD);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    rbs_bank #(.ROW_W(ROW_W), .T_RP(T_RP), .T_RCD(T_RCD), .T_CL(T_CL)) u_bank (
      .clk, .rst_n,
      .cmd_en(pick && (sel_bank == BK_W'(b))),
      .cmd_kind(sel_kind),
      .cmd_row(e_row[pick_idx]),
      .open_o(b_open[b]),
      .row_o(b_row[b]),
      .wait_done_o(b_wait[b]),
      .pre_ok_o(b_pre[b])
    );
  end

  // channel-wide read spacing and command register
  logic             cv_q;
  cmd_e             ck_q;
  logic [BK_W-1:0]  cb_q;
  logic [ROW_W-1:0] cr_q;
  logic [COL_W-1:0] cc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q <= '0;
      cv_q  <= 1'b0;
      ck_q  <= CMD_NOP;
      cb_q  <= '0;
      cr_q  <= '0;
      cc_q  <= '0;
    end else begin
      if (pop)               gap_q <= GW'(T_BURST - 1);
      else if (gap_q != '0)  gap_q <= gap_q - 1'b1;
      cv_q <= pick;
      ck_q <= pick ? sel_kind : CMD_NOP;
      cb_q <= sel_bank;
      cr_q <= e_row[pick_idx];
      cc_q <= e_col[pick_idx];
    end
  end

  assign cmd_valid = cv_q;
  assign cmd_kind  = ck_q;
  assign cmd_bank  = 3'(cb_q);
  assign cmd_row   = cr_q;
  assign cmd_col   = cc_q;

  rbs_beat #(.T_CL(T_CL), .T_BURST(T_BURST), .TAG_W(TAG_W)) u_beat (
    .clk, .rst_n,
    .cas_en(pop), .cas_tag(e_tag[pick_idx]),
    .dv_o(rd_valid), .dv_tag_o(rd_tag)
  );

  // checker: cycles since the last read on the bus, saturating
  logic [GW-1:0] since_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                          since_q <= GW'(T_BURST);
    else if (cv_q && ck_q == CMD_RD)     since_q <= GW'(1);
    else if (since_q < GW'(T_BURST))     since_q <= since_q + 1'b1;
  end

  p_cas_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_q && ck_q == CMD_RD) |-> (since_q >= GW'(T_BURST)));
  p_bus_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cv_q == (ck_q != CMD_NOP));
endmodule

// File: tb/rbs_sched_tb_top.sv
module rbs_sched_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_bank = '0;
  logic [13:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic [3:0]  req_tag = '0;
  logic        cmd_valid;
  logic [1:0]  cmd_kind;
  logic [2:0]  cmd_bank;
  logic [13:0] cmd_row;
  logic [9:0]  cmd_col;
  logic        rd_valid;
  logic [3:0]  rd_tag;

  always #5 clk = ~clk;

  rbs_sched dut_i (
    .clk, .rst_n, .req_valid, .req_ready, .req_bank, .req_row, .req_col, .req_tag,
    .cmd_valid, .cmd_kind, .cmd_bank, .cmd_row, .cmd_col, .rd_valid, .rd_tag
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  int exp_tag[$];
  int c_cyc[$], c_kind[$], c_bank[$];
  int d_cyc[$];

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: logs commands, scoreboards bursts
  int beats = 0;
  int last_rd = 0;
  bit seen_rd = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_valid) begin
        c_cyc.push_back(cyc);
        c_kind.push_back(int'(cmd_kind));
        c_bank.push_back(int'(cmd_bank));
        if (cmd_kind == 2'd3) begin
          if (seen_rd) chk(cyc - last_rd >= 4, "R5 read spacing", cyc - last_rd, 4);
          seen_rd = 1'b1;
          last_rd = cyc;
        end
      end
      if (rd_valid) begin
        if (beats == 0 || beats == 4) begin
          int e;
          e = (exp_tag.size() != 0) ? exp_tag.pop_front() : -1;
          chk(int'(rd_tag) == e, "R4 burst tag", int'(rd_tag), e);
          d_cyc.push_back(cyc);
          beats = 1;
        end else begin
          beats++;
        end
      end else if (beats != 0) begin
        chk(beats == 4, "R4 burst length", beats, 4);
        beats = 0;
      end
    end
  end

  task automatic send(int b, int r, int t, bit exp_push);
    req_valid = 1'b1;
    req_bank  = 3'(b);
    req_row   = 14'(r);
    req_col   = 10'(t);
    req_tag   = 4'(t);
    if (exp_push) exp_tag.push_back(t);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic next_cmd(output int cy, output int k, output int b);
    while (c_cyc.size() == 0) @(negedge clk);
    cy = c_cyc.pop_front();
    k  = c_kind.pop_front();
    b  = c_bank.pop_front();
  endtask

  task automatic next_data(output int cy);
    while (d_cyc.size() == 0) @(negedge clk);
    cy = d_cyc.pop_front();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cy, k, b, c0, c1, c2, d0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready out of reset", int'(req_ready), 1);
    chk(cmd_valid == 1'b0, "R7 bus idle in reset", int'(cmd_valid), 0);
    chk(rd_valid == 1'b0, "R4 no data in reset", int'(rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // closed bank: activate then read
    send(0, 5, 1, 1'b1);
    next_cmd(c0, k, b);
    chk(k == 2, "R1 first command is activate", k, 2);
    chk(b == 0, "R1 bank", b, 0);
    next_cmd(c1, k, b);
    chk(k == 3, "R2 read after activate", k, 3);
    chk(c1 - c0 == 13, "R2 activate-to-read gap", c1 - c0, 13);
    next_data(d0);
    chk(d0 - c1 == 13, "R4 read-to-data delay", d0 - c1, 13);

    // row hit: read only
    send(0, 5, 2, 1'b1);
    next_cmd(c0, k, b);
    chk(k == 3, "R3 hit issues read alone", k, 3);
    next_data(d0);
    chk(d0 - c0 == 13, "R10 hit latency", d0 - c0, 13);
    chk(c_cyc.size() == 0, "R3 no extra command on hit", c_cyc.size(), 0);

    // row miss
    send(0, 9, 3, 1'b1);
    next_cmd(c0, k, b);
    chk(k == 1, "R2 miss starts with precharge", k, 1);
    next_cmd(c1, k, b);
    chk(k == 2 && c1 - c0 == 13, "R2 precharge-to-activate", c1 - c0, 13);
    next_cmd(c2, k, b);
    chk(k == 3 && c2 - c1 == 13, "R2 activate-to-read", c2 - c1, 13);
    next_data(d0);
    chk(d0 - c0 == 39, "R10 miss latency", d0 - c0, 39);

    // hit then miss on the same bank: precharge waits CL after the read
    send(0, 9, 4, 1'b1);
    send(0, 2, 5, 1'b1);
    next_cmd(c0, k, b);
    chk(k == 3, "R3 hit read", k, 3);
    next_cmd(c1, k, b);
    chk(k == 1, "R6 precharge follows", k, 1);
    chk(c1 - c0 == 13, "R6 read-to-precharge gap", c1 - c0, 13);
    next_cmd(c2, k, b);
    next_cmd(c2, k, b);
    chk(k == 3, "R2 read after reopen", k, 3);
    next_data(d0);
    next_data(d0);

    // three closed banks back to back
    send(1, 1, 6, 1'b1);
    send(2, 1, 7, 1'b1);
    send(3, 1, 8, 1'b1);
    next_cmd(c0, k, b);
    next_cmd(c1, k, b);
    chk(k == 2 && b == 2 && c1 - c0 == 1, "R7 consecutive activates", c1 - c0, 1);
    next_cmd(c2, k, b);
    chk(k == 2 && b == 3 && c2 - c1 == 1, "R7 consecutive activates", c2 - c1, 1);
    next_cmd(c0, k, b);
    chk(k == 3 && b == 1, "R8 oldest read first", b, 1);
    next_cmd(c1, k, b);
    chk(c1 - c0 == 4, "R5 read spacing exact", c1 - c0, 4);
    next_cmd(c2, k, b);
    chk(c2 - c1 == 4 && b == 3, "R5 read spacing exact", c2 - c1, 4);
    repeat (3) next_data(d0);

    // younger hit passes an older request waiting on its activate
    send(5, 3, 9, 1'b0);
    send(1, 1, 10, 1'b0);
    exp_tag.push_back(10);
    exp_tag.push_back(9);
    next_cmd(c0, k, b);
    chk(k == 2 && b == 5, "R8 older activate first", b, 5);
    next_cmd(c1, k, b);
    chk(k == 3 && b == 1, "R8 younger hit proceeds", b, 1);
    next_cmd(c2, k, b);
    chk(k == 3 && b == 5, "R8 older read later", b, 5);
    repeat (2) next_data(d0);

    // fill the queue with misses to one bank
    send(4, 1, 11, 1'b1);
    send(4, 2, 12, 1'b1);
    send(4, 3, 13, 1'b1);
    send(4, 4, 14, 1'b1);
    chk(req_ready == 1'b0, "R9 ready low when full", int'(req_ready), 0);
    send(4, 5, 15, 1'b1);
    repeat (5) next_data(d0);
    repeat (30) @(negedge clk);
    chk(exp_tag.size() == 0, "R8 all tags delivered in order", exp_tag.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule